// File: doc/BRIEF.md
# Rectangular Block Copy Sequencer

This block steps a rectangular copy over word-addressed memory. Software sets up a width and a height in words, an ascending or descending direction, a start pointer and a signed row modulo for each of four channels, channel enables, and two edge masks. A start pulse launches the copy. From then on the block issues one memory slot per clock. For each destination word it reads every enabled source channel (A, then B, then C) and then gives one write slot. A final flush slot ends the copy.

The block keeps column and row counters. From them it builds the edge mask for channel A and decides when each pointer takes its row modulo. Each destination write is held for one write slot before it reaches memory, so the flush slot has to commit the last word. Its only data path is a pass-through: the destination word is the latest channel-A word ANDed with the current A mask. This makes the sequencing visible in memory. Memory is a single synchronous port, and read data returns on the clock after a read slot.

Top module: `blit_copy_seq`

## Requirements
- R1: After reset, and whenever no copy is running, `busy`, `bus_used`, `blit_irq`, `mem_rd` and `mem_wr` are all low.
- R2: `start` launches a copy only when the block is idle. The block latches all configuration on that cycle. A `start` pulse during a copy, or a configuration change during a copy, has no effect on that copy or on what follows it.
- R3: For each destination word there is one read slot for each enabled source, in the order A, B, C, followed by one write slot. One flush slot follows the final write slot. A copy therefore takes width×height×(sources+1)+1 slots. Enable bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D. The write slot occurs whatever the D enable bit holds.
- R4: The written word is the latest A word ANDed with the A mask. The A mask is `cfg_first_mask` in column 0, `cfg_last_mask` in column width−1, the AND of both when width is 1, and all ones in every other column.
- R5: Every pointer moves by +1 per access when `cfg_desc`=0 and by −1 when `cfg_desc`=1.
- R6: When a row after the first begins, each channel whose enable bit is set adds its modulo times the direction (±1) to its pointer before that word's accesses. A channel whose bit is clear adds nothing. No modulo is applied after the last row.
- R7: Every memory address is the pointer ANDed with `cfg_addr_mask`.
- R8: The first write slot of a copy only captures the word and its address. Each later write slot first commits the previously captured word. The flush slot commits the last one. A copy performs exactly width×height writes, and one of them falls in the flush slot.
- R9: `blit_irq` is high for exactly one cycle, during the flush slot, and `busy` is low on the cycle after it.
- R10: After a copy, `not_zero` is high if and only if at least one word written by that copy was nonzero. Starting a copy clears it.
- R11: `bus_used` is high in every slot of a copy, including the capture-only write slot and the flush slot. It is low in idle slots, which perform no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a copy (ignored while busy) |
| cfg_width | input | CNT_W | Words per row, at least 1 |
| cfg_height | input | CNT_W | Rows, at least 1 |
| cfg_desc | input | 1 | 1 = descending addresses |
| cfg_chan_en | input | 4 | Enables: bit0 A, bit1 B, bit2 C, bit3 D |
| cfg_ptr_a | input | PTR_W | Channel A start pointer |
| cfg_ptr_b | input | PTR_W | Channel B start pointer |
| cfg_ptr_c | input | PTR_W | Channel C start pointer |
| cfg_ptr_d | input | PTR_W | Destination start pointer |
| cfg_mod_a | input | MOD_W | Channel A signed row modulo |
| cfg_mod_b | input | MOD_W | Channel B signed row modulo |
| cfg_mod_c | input | MOD_W | Channel C signed row modulo |
| cfg_mod_d | input | MOD_W | Destination signed row modulo |
| cfg_first_mask | input | DATA_W | A mask for column 0 |
| cfg_last_mask | input | DATA_W | A mask for the last column |
| cfg_addr_mask | input | PTR_W | Mask applied to every address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | PTR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |
| busy | output | 1 | Copy in progress |
| bus_used | output | 1 | Current slot uses the bus |
| blit_irq | output | 1 | Completion pulse |
| not_zero | output | 1 | Some written word was nonzero |

## Verification
A wrong column or row counter shows up at the next row boundary. It surfaces as a mask applied to the wrong word, or as a modulo skipped or applied twice, and either one leaves a misplaced or corrupted word, or a clobbered guard word, in destination memory. A wrong slot state changes the slot count between start and the interrupt, and the count is measured exactly. A broken write lag loses the final word or writes one too many, and it shows in the write count and at the flush slot. Leakage of state between copies is caught by running copies back to back and checking the not-zero result.

// File: rtl/blit_pkg.sv
package blit_pkg;

    typedef enum logic [2:0] {
        SLOT_IDLE  = 3'd0,
        SLOT_A     = 3'd1,
        SLOT_B     = 3'd2,
        SLOT_C     = 3'd3,
        SLOT_W     = 3'd4,
        SLOT_FLUSH = 3'd5
    } slot_e;

    // Slot that follows cur among the enabled sources; SLOT_IDLE as cur
    // yields the first slot of a word.
    function automatic slot_e next_src_slot(input slot_e cur, input logic [2:0] src_en);
        slot_e nxt;
        nxt = SLOT_W;
        case (cur)
            SLOT_IDLE: begin
                if (src_en[0])      nxt = SLOT_A;
                else if (src_en[1]) nxt = SLOT_B;
                else if (src_en[2]) nxt = SLOT_C;
            end
            SLOT_A: begin
                if (src_en[1])      nxt = SLOT_B;
                else if (src_en[2]) nxt = SLOT_C;
            end
            SLOT_B: begin
                if (src_en[2])      nxt = SLOT_C;
            end
            default: nxt = SLOT_W;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/blit_slot_seq.sv
module blit_slot_seq
    import blit_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [2:0]  src_en,
    input  logic        last_word,
    output slot_e       slot,
    output logic        iter_start
);

    typedef struct packed {
        slot_e slot;
        logic  final_word;
    } seq_t;

    seq_t s_q, s_d;
    slot_e first_slot;
    logic  final_now;

    always_comb begin
        first_slot = next_src_slot(SLOT_IDLE, src_en);
        iter_start = (s_q.slot != SLOT_IDLE) && (s_q.slot != SLOT_FLUSH)
                     && (s_q.slot == first_slot);
        final_now  = s_q.final_word | (iter_start & last_word);
        s_d        = s_q;
        case (s_q.slot)
            SLOT_IDLE: begin
                if (go) begin
                    s_d.slot       = first_slot;
                    s_d.final_word = 1'b0;
                end
            end
            SLOT_A, SLOT_B, SLOT_C: begin
                s_d.slot       = next_src_slot(s_q.slot, src_en);
                s_d.final_word = final_now;
            end
            SLOT_W: begin
                s_d.slot       = final_now ? SLOT_FLUSH : first_slot;
                s_d.final_word = final_now;
            end
            default: begin
                s_d.slot       = SLOT_IDLE;
                s_d.final_word = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.slot       <= SLOT_IDLE;
            s_q.final_word <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign slot = s_q.slot;

    AST_FLUSH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.slot == SLOT_FLUSH) |-> ($past(s_q.slot) == SLOT_W)); // R3
    AST_COPY_RUNS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.slot inside {SLOT_A, SLOT_B, SLOT_C, SLOT_W}) |=> (s_q.slot != SLOT_IDLE)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.slot == SLOT_IDLE && !go) |=> (s_q.slot == SLOT_IDLE)); // R1

endmodule

// File: rtl/blit_word_cnt.sv
module blit_word_cnt #(
    parameter int CNT_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CNT_W-1:0]  width,
    input  logic [CNT_W-1:0]  height,
    input  logic [DATA_W-1:0] first_mask,
    input  logic [DATA_W-1:0] last_mask,
    input  logic              iter_start,
    output logic [DATA_W-1:0] a_mask,
    output logic              row_start,
    output logic              last_word
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0]  w;
        logic [CNT_W-1:0]  h;
        logic [CNT_W-1:0]  col;
        logic [CNT_W-1:0]  row;
        logic [DATA_W-1:0] fm;
        logic [DATA_W-1:0] lm;
        logic [DATA_W-1:0] mask;
    } cnt_t;

    cnt_t c_q, c_d;
    logic [CNT_W-1:0]  col_inc, row_inc;
    logic              col_end;
    logic [DATA_W-1:0] mask_new;

    always_comb begin
        col_inc   = c_q.col + 1'b1;
        row_inc   = c_q.row + 1'b1;
        col_end   = (col_inc == c_q.w);
        mask_new  = (c_q.col == '0) ? c_q.fm : ALL_ONES;
        if (col_end) mask_new = mask_new & c_q.lm;
        row_start = iter_start && (c_q.col == '0) && (c_q.row != '0);
        last_word = iter_start && col_end && (row_inc == c_q.h);
        a_mask    = iter_start ? mask_new : c_q.mask;

        c_d = c_q;
        if (go) begin
            c_d.w    = width;
            c_d.h    = height;
            c_d.fm   = first_mask;
            c_d.lm   = last_mask;
            c_d.col  = '0;
            c_d.row  = '0;
            c_d.mask = ALL_ONES;
        end else if (iter_start) begin
            c_d.mask = mask_new;
            if (col_end) begin
                c_d.col = '0;
                c_d.row = row_inc;
            end else begin
                c_d.col = col_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.w != '0) |-> (c_q.col < c_q.w)); // R4
    AST_ROW_NOT_PAST: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.row <= c_q.h)); // R6

endmodule

// File: rtl/blit_chan_ptr.sv
module blit_chan_ptr #(
    parameter int PTR_W = 20,
    parameter int MOD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [PTR_W-1:0] init,
    input  logic [MOD_W-1:0] modulo,
    input  logic             en,
    input  logic             desc,
    input  logic             row_start,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);

    localparam int EXT_W = PTR_W - MOD_W;

    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [PTR_W-1:0] mod_ext, adj, inc;

    always_comb begin
        mod_ext = {{EXT_W{modulo[MOD_W-1]}}, modulo};
        adj     = '0;
        if (row_start && en) adj = desc ? (~mod_ext + 1'b1) : mod_ext;
        ptr     = ptr_q + adj;
        inc     = '0;
        if (step) inc = desc ? {PTR_W{1'b1}} : {{(PTR_W-1){1'b0}}, 1'b1};
        ptr_d   = go ? init : (ptr + inc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    AST_STEP_IS_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !row_start && !go) |=>
        ((ptr_q - $past(ptr_q)) == ($past(desc) ? {PTR_W{1'b1}} : {{(PTR_W-1){1'b0}}, 1'b1}))); // R5

endmodule

// File: rtl/blit_copy_seq.sv
module blit_copy_seq
    import blit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 20,
    parameter int MOD_W  = 16,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  cfg_width,
    input  logic [CNT_W-1:0]  cfg_height,
    input  logic              cfg_desc,
    input  logic [3:0]        cfg_chan_en,
    input  logic [PTR_W-1:0]  cfg_ptr_a,
    input  logic [PTR_W-1:0]  cfg_ptr_b,
    input  logic [PTR_W-1:0]  cfg_ptr_c,
    input  logic [PTR_W-1:0]  cfg_ptr_d,
    input  logic [MOD_W-1:0]  cfg_mod_a,
    input  logic [MOD_W-1:0]  cfg_mod_b,
    input  logic [MOD_W-1:0]  cfg_mod_c,
    input  logic [MOD_W-1:0]  cfg_mod_d,
    input  logic [DATA_W-1:0] cfg_first_mask,
    input  logic [DATA_W-1:0] cfg_last_mask,
    input  logic [PTR_W-1:0]  cfg_addr_mask,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              bus_used,
    output logic              blit_irq,
    output logic              not_zero
);

    localparam int NCH  = 4;
    localparam int CH_D = NCH - 1;

    typedef struct packed {
        logic [NCH-1:0]             en;
        logic                       desc;
        logic [PTR_W-1:0]           amask;
        logic [NCH-1:0][MOD_W-1:0]  mods;
        logic                       a_rd;
        logic [DATA_W-1:0]          a_hold;
        logic                       pend_vld;
        logic [PTR_W-1:0]           pend_addr;
        logic [DATA_W-1:0]          pend_data;
        logic                       nz;
    } top_t;

    top_t s_q, s_d;

    slot_e                     slot;
    logic                      go, iter_start, row_start, last_word;
    logic [2:0]                src_en;
    logic [DATA_W-1:0]         a_mask, a_word, out_word;
    logic [NCH-1:0][PTR_W-1:0] init_ptr, ptr_eff;
    logic [NCH-1:0]            step;

    assign go       = start && (slot == SLOT_IDLE);
    assign src_en   = go ? cfg_chan_en[2:0] : s_q.en[2:0];
    assign init_ptr = {cfg_ptr_d, cfg_ptr_c, cfg_ptr_b, cfg_ptr_a};
    assign step[0]  = (slot == SLOT_A);
    assign step[1]  = (slot == SLOT_B);
    assign step[2]  = (slot == SLOT_C);
    assign step[3]  = (slot == SLOT_W);

    blit_slot_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .src_en     (src_en),
        .last_word  (last_word),
        .slot       (slot),
        .iter_start (iter_start)
    );

    blit_word_cnt #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .width      (cfg_width),
        .height     (cfg_height),
        .first_mask (cfg_first_mask),
        .last_mask  (cfg_last_mask),
        .iter_start (iter_start),
        .a_mask     (a_mask),
        .row_start  (row_start),
        .last_word  (last_word)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ptr
        blit_chan_ptr #(.PTR_W(PTR_W), .MOD_W(MOD_W)) u_ptr (
            .clk       (clk),
            .rst_n     (rst_n),
            .go        (go),
            .init      (init_ptr[ch]),
            .modulo    (s_q.mods[ch]),
            .en        (s_q.en[ch]),
            .desc      (s_q.desc),
            .row_start (row_start),
            .step      (step[ch]),
            .ptr       (ptr_eff[ch])
        );
    end

    always_comb begin
        a_word   = s_q.a_rd ? mem_rdata : s_q.a_hold;
        out_word = a_word & a_mask;

        mem_rd    = (slot == SLOT_A) || (slot == SLOT_B) || (slot == SLOT_C);
        mem_wr    = ((slot == SLOT_W) || (slot == SLOT_FLUSH)) && s_q.pend_vld;
        mem_wdata = s_q.pend_data;
        case (slot)
            SLOT_A:  mem_addr = ptr_eff[0] & s_q.amask;
            SLOT_B:  mem_addr = ptr_eff[1] & s_q.amask;
            SLOT_C:  mem_addr = ptr_eff[2] & s_q.amask;
            default: mem_addr = s_q.pend_addr;
        endcase

        s_d        = s_q;
        s_d.a_rd   = (slot == SLOT_A);
        s_d.a_hold = a_word;
        if (go) begin
            s_d.en       = cfg_chan_en;
            s_d.desc     = cfg_desc;
            s_d.amask    = cfg_addr_mask;
            s_d.mods     = {cfg_mod_d, cfg_mod_c, cfg_mod_b, cfg_mod_a};
            s_d.a_hold   = '0;
            s_d.pend_vld = 1'b0;
            s_d.nz       = 1'b0;
        end else if (slot == SLOT_W) begin
            s_d.pend_vld  = 1'b1;
            s_d.pend_addr = ptr_eff[CH_D] & s_q.amask;
            s_d.pend_data = out_word;
            s_d.nz        = s_q.nz | (|out_word);
        end else if (slot == SLOT_FLUSH) begin
            s_d.pend_vld  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (slot != SLOT_IDLE);
    assign bus_used = (slot != SLOT_IDLE);
    assign blit_irq = (slot == SLOT_FLUSH);
    assign not_zero = s_q.nz;

    AST_WRITE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> s_q.pend_vld); // R8
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        blit_irq |=> (!blit_irq && !busy)); // R9
    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_used |-> (!mem_rd && !mem_wr)); // R11
    AST_ADDR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> ((mem_addr & ~s_q.amask) == '0)); // R7
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R3

endmodule

// File: tb/blit_copy_seq_test.sv
`timescale 1ns/1ps
module blit_copy_seq_test;

    localparam int MEM_N = 512;

    typedef struct packed {
        logic [7:0]  w;
        logic [7:0]  h;
        logic        desc;
        logic [3:0]  en;
        logic [19:0] a0;
        logic [19:0] d0;
        logic [15:0] ma;
        logic [15:0] md;
        logic [15:0] fm;
        logic [15:0] lm;
        logic [19:0] am;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'd3, 8'd2, 1'b0, 4'b1001, 20'h00010, 20'h00100, 16'd2, 16'd1, 16'hFFF0, 16'h0FFF, 20'h001FF},
        '{8'd1, 8'd3, 1'b0, 4'b1111, 20'h00020, 20'h00120, 16'd3, 16'd4, 16'h00FF, 16'hF0F0, 20'h001FF},
        '{8'd4, 8'd2, 1'b1, 4'b1011, 20'h000F0, 20'h001F0, 16'd1, 16'd2, 16'hFFFF, 16'hFFFF, 20'h001FF},
        '{8'd2, 8'd2, 1'b0, 4'b0001, 20'h00040, 20'h00140, 16'd0, 16'd5, 16'hFFFF, 16'hFFFF, 20'h001FF},
        '{8'd2, 8'd1, 1'b0, 4'b1001, 20'h00040, 20'h00150, 16'd0, 16'd0, 16'h0000, 16'h0000, 20'h001FF},
        '{8'd2, 8'd2, 1'b0, 4'b1101, 20'h00050, 20'h003A0, 16'd0, 16'd0, 16'hFFFF, 16'h00FF, 20'h001FF},
        '{8'd1, 8'd1, 1'b0, 4'b1001, 20'h00060, 20'h00160, 16'd0, 16'd0, 16'h0FF0, 16'h3C3C, 20'h001FF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  cfg_width = '0, cfg_height = '0;
    logic        cfg_desc = 1'b0;
    logic [3:0]  cfg_chan_en = '0;
    logic [19:0] cfg_ptr_a = '0, cfg_ptr_b = 20'h00180, cfg_ptr_c = 20'h001C0, cfg_ptr_d = '0;
    logic [15:0] cfg_mod_a = '0, cfg_mod_b = 16'd1, cfg_mod_c = 16'd2, cfg_mod_d = '0;
    logic [15:0] cfg_first_mask = '0, cfg_last_mask = '0;
    logic [19:0] cfg_addr_mask = '0;
    logic        mem_rd, mem_wr, busy, bus_used, blit_irq, not_zero;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    logic [15:0] mem [MEM_N];
    logic        init_req = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    blit_copy_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_desc(cfg_desc),
        .cfg_chan_en(cfg_chan_en),
        .cfg_ptr_a(cfg_ptr_a), .cfg_ptr_b(cfg_ptr_b), .cfg_ptr_c(cfg_ptr_c), .cfg_ptr_d(cfg_ptr_d),
        .cfg_mod_a(cfg_mod_a), .cfg_mod_b(cfg_mod_b), .cfg_mod_c(cfg_mod_c), .cfg_mod_d(cfg_mod_d),
        .cfg_first_mask(cfg_first_mask), .cfg_last_mask(cfg_last_mask),
        .cfg_addr_mask(cfg_addr_mask),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .busy(busy), .bus_used(bus_used), .blit_irq(blit_irq), .not_zero(not_zero)
    );

    function automatic logic [15:0] seed_word(input int i);
        return 16'(i * 313) ^ 16'hA5C3;
    endfunction

    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= seed_word(i);
        end else begin
            if (mem_wr) mem[mem_addr[8:0]] <= mem_wdata;
            if (mem_rd) mem_rdata <= mem[mem_addr[8:0]];
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int addr_of(input int base, input bit desc, input int r, input int c,
                                   input int w, input int mod, input int am);
        int off;
        off = r * (w + mod) + c;
        return (desc ? base - off : base + off) & am;
    endfunction

    task automatic run_vec(input vec_t v, input bit poke);
        int slots, wrs, oob, w, h, nsrc, mda, mdd;
        bit irq_seen, wr_in_flush, exp_nz, stay_idle;
        int bad_words;
        @(negedge clk) init_req = 1'b1;
        @(negedge clk) init_req = 1'b0;
        cfg_width = 10'(v.w); cfg_height = 10'(v.h); cfg_desc = v.desc;
        cfg_chan_en = v.en; cfg_ptr_a = v.a0; cfg_ptr_d = v.d0;
        cfg_mod_a = v.ma; cfg_mod_d = v.md;
        cfg_first_mask = v.fm; cfg_last_mask = v.lm; cfg_addr_mask = v.am;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        slots = 0; wrs = 0; oob = 0; irq_seen = 0; wr_in_flush = 0;
        for (int k = 0; k < 3000; k++) begin
            if (poke && k == 3) begin
                start = 1'b1; cfg_width = 10'd7; cfg_ptr_d = 20'h0;
                cfg_first_mask = 16'h0; cfg_chan_en = 4'b1111;
            end
            if (poke && k == 4) start = 1'b0;
            if (bus_used) slots++;
            if (mem_wr) wrs++;
            if ((mem_rd || mem_wr) && ((mem_addr & ~v.am) != 0)) oob++;
            if (blit_irq) begin
                irq_seen = 1'b1;
                wr_in_flush = mem_wr;
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        w = int'(v.w); h = int'(v.h);
        nsrc = int'(v.en[0]) + int'(v.en[1]) + int'(v.en[2]);
        mda = v.en[0] ? int'($signed(v.ma)) : 0;
        mdd = v.en[3] ? int'($signed(v.md)) : 0;
        chk(irq_seen, "R9", "irq seen", int'(irq_seen), 1);
        chk(!blit_irq && !busy, "R9", "irq one cycle then not busy", int'(blit_irq) + int'(busy), 0);
        chk(slots == w * h * (nsrc + 1) + 1, "R3", "slot count", slots, w * h * (nsrc + 1) + 1);
        chk(wrs == w * h, "R8", "write count", wrs, w * h);
        chk(wr_in_flush, "R8", "last commit in flush", int'(wr_in_flush), 1);
        chk(oob == 0, "R7", "addresses outside mask", oob, 0);
        bad_words = 0; exp_nz = 0;
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                logic [15:0] m, e;
                int da, sa;
                m = 16'hFFFF;
                if (c == 0) m = m & v.fm;
                if (c == w - 1) m = m & v.lm;
                sa = addr_of(int'(v.a0), v.desc, r, c, w, mda, int'(v.am));
                da = addr_of(int'(v.d0), v.desc, r, c, w, mdd, int'(v.am));
                e = seed_word(sa % MEM_N) & m;
                if (e != 0) exp_nz = 1'b1;
                if (mem[da % MEM_N] !== e) bad_words++;
            end
        end
        chk(bad_words == 0, "R4 R5 R6", "destination words wrong", bad_words, 0);
        begin
            int ga;
            ga = addr_of(int'(v.d0), v.desc, h - 1, w, w, mdd, int'(v.am));
            chk(mem[ga % MEM_N] === seed_word(ga % MEM_N), "R6", "guard word past end",
                int'(mem[ga % MEM_N]), int'(seed_word(ga % MEM_N)));
        end
        chk(not_zero == exp_nz, "R10", "not_zero", int'(not_zero), int'(exp_nz));
        stay_idle = 1'b1;
        for (int k = 0; k < 5; k++) begin
            if (bus_used || mem_rd || mem_wr || busy) stay_idle = 1'b0;
            @(negedge clk);
        end
        chk(stay_idle, poke ? "R2" : "R11", "idle after copy", int'(stay_idle), 1);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !bus_used && !blit_irq && !mem_rd && !mem_wr, "R1", "reset outputs",
            int'(busy) + int'(bus_used) + int'(blit_irq) + int'(mem_rd) + int'(mem_wr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_used && !not_zero, "R1", "idle after reset release",
            int'(busy) + int'(bus_used) + int'(not_zero), 0);
        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);
        run_vec(VECS[0], 1'b1);
        run_vec(VECS[4], 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule